// File: doc/BRIEF.md
# Precise Trap Controller

This block decides, cycle by cycle, whether a five-stage pipeline must abandon its normal flow for a trap. Two sources may request a trap. The decode stage reports an unrecognised opcode. The execute stage reports an arithmetic overflow. Each request comes with the address of the instruction that raised it. When either request is present, the controller takes the trap in that same cycle. It raises squash strobes for the pipeline registers that hold the faulting instruction and everything fetched after it, and it presents the address of the trap handler as the new fetch address.

On the next clock edge the controller records two values. The saved-PC register gets the faulting address plus one instruction width. The reason register gets a code for the cause. If both stages fault in the same cycle, the execute-stage instruction is older, so it wins and the decode-stage fault is discarded together with the rest of the squashed work. A mode input picks the handler address. With the mode low, every trap goes to one common entry. With the mode high, each cause has its own entry, spaced at a fixed stride above a vector base.

Top module: `trap_ctrl`

## Requirements
- R1: After reset, the saved-PC and reason outputs are zero. While no request is present, take_o, all three squash strobes and redirect_pc_o are low.
- R2: An execute-stage overflow alone raises take_o, sq_ifid_o, sq_idex_o and sq_exmem_o in the same cycle. Squashing EX/MEM keeps the faulting instruction from writing its destination register.
- R3: A decode-stage undefined opcode alone raises take_o, sq_ifid_o and sq_idex_o in the same cycle and leaves sq_exmem_o low.
- R4: When both requests are present in one cycle, the overflow is taken. The reason becomes 1, the saved PC becomes ex_pc_i + 4, and sq_exmem_o is high.
- R5: On the clock edge that ends a cycle with take_o high, the saved PC becomes the faulting instruction's address plus 4.
- R6: The reason code is 0 for an undefined opcode and 1 for an overflow, zero-extended to the full register width.
- R7: With vec_mode_i low, redirect_pc_o is 0x80000180 for either cause.
- R8: With vec_mode_i high, redirect_pc_o is 0xC0000000 for an undefined opcode and 0xC0000020 for an overflow. The base is 0xC0000000 and the stride is 0x20 per cause code.
- R9: Saved PC and reason change only on an edge where a trap is taken. Otherwise they hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| vec_mode_i | input | 1 | 1 selects per-cause handler entries |
| id_undef_i | input | 1 | Decode stage holds an unrecognised opcode |
| id_pc_i | input | XLEN | Address of the decode-stage instruction |
| ex_ovf_i | input | 1 | Execute stage produced an overflow |
| ex_pc_i | input | XLEN | Address of the execute-stage instruction |
| take_o | output | 1 | A trap is taken this cycle |
| redirect_pc_o | output | XLEN | Handler address while take_o is high, else zero |
| sq_ifid_o | output | 1 | Squash the IF/ID register |
| sq_idex_o | output | 1 | Squash the ID/EX register |
| sq_exmem_o | output | 1 | Squash the EX/MEM register |
| epc_o | output | XLEN | Saved PC of the last trap |
| cause_o | output | XLEN | Reason code of the last trap |

## Verification
The assertions assume that a request and its address are valid during the whole cycle before the clock edge. They also assume that a request stays low while the pipeline is held in reset, because the saved values track the request ports only on edges taken out of reset. The bench changes the request inputs only on falling edges and clears them during reset. It checks the squash strobes and the redirect address half a cycle later, and it reads the saved registers one falling edge after the capturing rising edge.

// File: rtl/trap_pkg.sv
package trap_pkg;
   typedef enum logic [0:0] {
      RSN_UNDEF = 1'b0,
      RSN_OVF   = 1'b1
   } reason_e;
   localparam int unsigned REASON_W = 1;
endpackage

// File: rtl/trap_prio.sv
module trap_prio
   import trap_pkg::*;
(
   input  logic    id_undef_i,
   input  logic    ex_ovf_i,
   output logic    take_o,
   output logic    from_ex_o,
   output reason_e reason_o
);
   // The execute stage holds the older instruction, so it wins.
   always_comb begin
      take_o    = id_undef_i | ex_ovf_i;
      from_ex_o = ex_ovf_i;
      reason_o  = ex_ovf_i ? RSN_OVF : RSN_UNDEF;
   end
endmodule

// File: rtl/trap_target.sv
module trap_target
   import trap_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter logic [XLEN-1:0] SINGLE_ENTRY = 32'h8000_0180,
   parameter logic [XLEN-1:0] VEC_BASE     = 32'hC000_0000,
   parameter int unsigned     VEC_SHIFT    = 5
) (
   input  logic            vec_mode_i,
   input  reason_e         reason_i,
   output logic [XLEN-1:0] target_o
);
   localparam int unsigned SPAN = VEC_SHIFT + REASON_W;
   localparam logic [SPAN-1:0] BASE_LOW = VEC_BASE[SPAN-1:0];

   logic [XLEN-1:0] vec_addr;

   if (VEC_SHIFT + REASON_W > XLEN) begin : g_bad_shift
      $error("trap_target: VEC_SHIFT too large for XLEN");
   end

   // When the base has no bits set under the vector span, a plain
   // concatenation replaces the adder.
   if (BASE_LOW == '0) begin : g_or_vec
      assign vec_addr = {VEC_BASE[XLEN-1:SPAN], reason_i, {VEC_SHIFT{1'b0}}};
   end else begin : g_add_vec
      assign vec_addr = VEC_BASE + (XLEN'(reason_i) << VEC_SHIFT);
   end

   assign target_o = vec_mode_i ? vec_addr : SINGLE_ENTRY;
endmodule

// File: rtl/trap_regs.sv
module trap_regs
   import trap_pkg::*;
#(
   parameter int unsigned XLEN       = 32,
   parameter int unsigned INSN_BYTES = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_i,
   input  reason_e         reason_i,
   input  logic [XLEN-1:0] pc_i,
   output logic [XLEN-1:0] epc_o,
   output logic [XLEN-1:0] cause_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         epc_o   <= '0;
         cause_o <= '0;
      end else if (we_i) begin
         epc_o   <= pc_i + STEP;
         cause_o <= XLEN'(reason_i);
      end
   end

   assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> ($stable(epc_o) && $stable(cause_o)));

   assert_reason_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
      we_i |=> (cause_o[XLEN-1:1] == '0));
endmodule

// File: rtl/trap_ctrl.sv
module trap_ctrl
   import trap_pkg::*;
#(
   parameter int unsigned     XLEN         = 32,
   parameter int unsigned     INSN_BYTES   = 4,
   parameter logic [XLEN-1:0] SINGLE_ENTRY = 32'h8000_0180,
   parameter logic [XLEN-1:0] VEC_BASE     = 32'hC000_0000,
   parameter int unsigned     VEC_SHIFT    = 5
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            vec_mode_i,
   input  logic            id_undef_i,
   input  logic [XLEN-1:0] id_pc_i,
   input  logic            ex_ovf_i,
   input  logic [XLEN-1:0] ex_pc_i,
   output logic            take_o,
   output logic [XLEN-1:0] redirect_pc_o,
   output logic            sq_ifid_o,
   output logic            sq_idex_o,
   output logic            sq_exmem_o,
   output logic [XLEN-1:0] epc_o,
   output logic [XLEN-1:0] cause_o
);
   if (XLEN < 16) begin : g_bad_xlen
      $error("trap_ctrl: XLEN below 16");
   end
   if (INSN_BYTES == 0) begin : g_bad_step
      $error("trap_ctrl: INSN_BYTES must be nonzero");
   end

   logic            take;
   logic            from_ex;
   reason_e         reason;
   logic [XLEN-1:0] target;
   logic [XLEN-1:0] fault_pc;

   trap_prio u_prio (
      .id_undef_i (id_undef_i),
      .ex_ovf_i   (ex_ovf_i),
      .take_o     (take),
      .from_ex_o  (from_ex),
      .reason_o   (reason)
   );

   trap_target #(
      .XLEN         (XLEN),
      .SINGLE_ENTRY (SINGLE_ENTRY),
      .VEC_BASE     (VEC_BASE),
      .VEC_SHIFT    (VEC_SHIFT)
   ) u_target (
      .vec_mode_i (vec_mode_i),
      .reason_i   (reason),
      .target_o   (target)
   );

   assign fault_pc = from_ex ? ex_pc_i : id_pc_i;

   trap_regs #(
      .XLEN       (XLEN),
      .INSN_BYTES (INSN_BYTES)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .we_i     (take),
      .reason_i (reason),
      .pc_i     (fault_pc),
      .epc_o    (epc_o),
      .cause_o  (cause_o)
   );

   // Squash the faulting stage and every younger stage in the redirect cycle.
   assign take_o        = take;
   assign redirect_pc_o = take ? target : '0;
   assign sq_ifid_o     = take;
   assign sq_idex_o     = take;
   assign sq_exmem_o    = take & from_ex;

   assert_exmem_implies_younger_R2: assert property (@(posedge clk) disable iff (!rst_n)
      sq_exmem_o |-> (sq_idex_o && sq_ifid_o));

   assert_decode_spares_exmem_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (id_undef_i && !ex_ovf_i) |-> (take_o && !sq_exmem_o));

   assert_oldest_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ex_ovf_i |=> (epc_o == $past(ex_pc_i) + XLEN'(INSN_BYTES)) && (cause_o == XLEN'(1)));

   assert_epc_from_decode_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (id_undef_i && !ex_ovf_i) |=> (epc_o == $past(id_pc_i) + XLEN'(INSN_BYTES)) && (cause_o == '0));

   assert_single_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && !vec_mode_i) |-> (redirect_pc_o == SINGLE_ENTRY));

   assert_quiet_when_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (!id_undef_i && !ex_ovf_i) |-> (!take_o && !sq_ifid_o && !sq_idex_o && !sq_exmem_o));
endmodule

// File: tb/trap_ctrl_tb.sv
module trap_ctrl_tb;
   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            vec_mode_i = 1'b0;
   logic            id_undef_i = 1'b0;
   logic [XLEN-1:0] id_pc_i = '0;
   logic            ex_ovf_i = 1'b0;
   logic [XLEN-1:0] ex_pc_i = '0;
   logic            take_o;
   logic [XLEN-1:0] redirect_pc_o;
   logic            sq_ifid_o, sq_idex_o, sq_exmem_o;
   logic [XLEN-1:0] epc_o, cause_o;

   int n_checks = 0;
   int n_fail   = 0;

   always #5 clk = ~clk;

   trap_ctrl u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .vec_mode_i    (vec_mode_i),
      .id_undef_i    (id_undef_i),
      .id_pc_i       (id_pc_i),
      .ex_ovf_i      (ex_ovf_i),
      .ex_pc_i       (ex_pc_i),
      .take_o        (take_o),
      .redirect_pc_o (redirect_pc_o),
      .sq_ifid_o     (sq_ifid_o),
      .sq_idex_o     (sq_idex_o),
      .sq_exmem_o    (sq_exmem_o),
      .epc_o         (epc_o),
      .cause_o       (cause_o)
   );

   task automatic chk(input string req, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive a request at a falling edge, check the same-cycle outputs,
   // then check the captured registers one falling edge later.
   task automatic drive(input logic mode, input logic und, input logic [XLEN-1:0] ipc,
                        input logic ovf, input logic [XLEN-1:0] epc);
      @(negedge clk);
      vec_mode_i = mode; id_undef_i = und; id_pc_i = ipc;
      ex_ovf_i = ovf; ex_pc_i = epc;
      #1;
   endtask

   task automatic release_req();
      @(negedge clk);
      id_undef_i = 1'b0; ex_ovf_i = 1'b0;
      #1;
   endtask

   task automatic t_reset();
      chk("R1", "epc", epc_o, '0);
      chk("R1", "cause", cause_o, '0);
      chk("R1", "take", XLEN'(take_o), '0);
      chk("R1", "flushes", XLEN'({sq_ifid_o, sq_idex_o, sq_exmem_o}), '0);
      chk("R1", "redirect", redirect_pc_o, '0);
   endtask

   task automatic t_overflow_single();
      drive(1'b0, 1'b0, '0, 1'b1, 32'h4C);
      chk("R2", "take", XLEN'(take_o), 1);
      chk("R2", "flushes", XLEN'({sq_ifid_o, sq_idex_o, sq_exmem_o}), 32'h7);
      chk("R7", "redirect ovf", redirect_pc_o, 32'h8000_0180);
      release_req();
      chk("R5", "epc", epc_o, 32'h50);
      chk("R6", "cause ovf", cause_o, 1);
   endtask

   task automatic t_undef_single();
      drive(1'b0, 1'b1, 32'h100, 1'b0, '0);
      chk("R3", "flushes", XLEN'({sq_ifid_o, sq_idex_o, sq_exmem_o}), 32'h6);
      chk("R7", "redirect undef", redirect_pc_o, 32'h8000_0180);
      release_req();
      chk("R5", "epc", epc_o, 32'h104);
      chk("R6", "cause undef", cause_o, 0);
   endtask

   task automatic t_both();
      drive(1'b0, 1'b1, 32'h204, 1'b1, 32'h200);
      chk("R4", "exmem squash", XLEN'(sq_exmem_o), 1);
      release_req();
      chk("R4", "epc", epc_o, 32'h204);
      chk("R4", "cause", cause_o, 1);
   endtask

   task automatic t_vectored();
      drive(1'b1, 1'b1, 32'h300, 1'b0, '0);
      chk("R8", "vec undef", redirect_pc_o, 32'hC000_0000);
      drive(1'b1, 1'b0, '0, 1'b1, 32'h400);
      chk("R8", "vec ovf", redirect_pc_o, 32'hC000_0020);
      release_req();
      chk("R5", "epc vec", epc_o, 32'h404);
      vec_mode_i = 1'b0;
   endtask

   task automatic t_hold();
      // Addresses change but no request is raised.
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         id_pc_i = 32'h1000 + i; ex_pc_i = 32'h2000 + i;
      end
      @(negedge clk); #1;
      chk("R9", "epc hold", epc_o, 32'h404);
      chk("R9", "cause hold", cause_o, 1);
      chk("R1", "idle take", XLEN'(take_o), 0);
      chk("R1", "idle redirect", redirect_pc_o, 0);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      t_reset();
      t_overflow_single();
      t_undef_single();
      t_both();
      t_vectored();
      t_hold();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule